// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter (Bus Master)

This block is the master end of a three-wire stereo audio link. It generates a free-running bit clock and a word-select line, and it shifts two's-complement PCM samples out on one serial data line. Each sample goes out most significant bit first. Left and right words share the data line and alternate. The word-select line names the channel, and it toggles one bit period before the first bit of the word it announces.

The host offers one stereo pair at a time through a parallel ready/valid port. Once per frame, in the system clock cycle just before the left slot opens, the block raises `inReady` for one cycle. If `inValid` is high in that cycle, the pair is copied into a holding register. If it is low, the pair held from the previous frame goes out again.

Two compile-time parameters set the behaviour. `WORD_LEN` selects 16, 18, 20 or 24 bits per word. `CLK_DIV` is an even number of system clocks per bit-clock period. Every output changes on the rising system clock edge.

Top module: `i2s_tx_master`

## Requirements
- R1: `sckOut` is low in reset. After reset it toggles every `CLK_DIV/2` system clocks without pause, which gives a period of `CLK_DIV` clocks and a 50% duty cycle.
- R2: Each channel slot lasts exactly `WORD_LEN` bit-clock periods. The left slot (channel 1) comes first in each frame, and the right slot (channel 2) follows.
- R3: `wsOut` is 0 for the left word and 1 for the right word. It changes in the bit period that carries the LSB of the preceding word, one period before the MSB of the next word. This makes it 1 during the left LSB period and 0 during the right LSB period.
- R4: `sdOut` carries each word MSB first, one bit per bit-clock period. `sdOut` and `wsOut` change only in the system clock cycle in which `sckOut` falls, so that they are stable at every rising edge of `sckOut`.
- R5: `inReady` is high for exactly one system clock, once per frame, every `2*WORD_LEN*CLK_DIV` clocks. The next cycle holds the falling bit-clock edge that opens the left slot. If `inValid` is high in the `inReady` cycle, `inLeft` and `inRight` are captured, and the MSB of `inLeft` appears on `sdOut` in the next cycle.
- R6: If `inValid` is low in the `inReady` cycle, the previously captured pair is sent again unchanged. The holding register resets to zero.
- R7: In reset, `sckOut`, `wsOut`, `sdOut` and `inReady` are all 0. The first falling edge of `sckOut` after reset opens the first left slot. The rising edge before it, at which `wsOut` and `sdOut` are both 0, belongs to no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| inLeft | input | WORD_LEN | Left sample, two's complement |
| inRight | input | WORD_LEN | Right sample, two's complement |
| inValid | input | 1 | The sample pair on the inputs is valid |
| inReady | output | 1 | One-cycle capture window for the pair |
| sckOut | output | 1 | Serial bit clock |
| wsOut | output | 1 | Word select: 0 left, 1 right |
| sdOut | output | 1 | Serial data, MSB first |

## Verification
The assertions check the following on every cycle:
- Each half period of the bit clock is exactly `CLK_DIV/2` system clocks, and the bit clock never stalls.
- The data and word-select lines move only on falling edges of the bit clock.
- `inReady` is a lone pulse that is followed by a falling edge with word select low.
- An accepted pair puts its left MSB on the line at once.

Only the bench scenarios can show the following:
- The word contents and the MSB-first order.
- The exact bit period in which word select toggles relative to each LSB.
- The left/right alternation.
- The repetition of a held pair when no valid pair is offered, including the zero pair from reset.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  // Strobes from the control unit to the datapath; each is a single-cycle
  // pulse coincident with a falling bit-clock edge.
  typedef struct packed {
    logic loadLeft;   // open left slot: capture pair, send left MSB
    logic loadRight;  // open right slot: send right MSB
    logic shift;      // next bit of the current word
  } txStrobes_t;

endpackage

// File: rtl/i2s_tx_ctrl.sv
module i2s_tx_ctrl
  import i2s_tx_pkg::*;
#(
  parameter int WORD_LEN = 24,
  parameter int CLK_DIV  = 8
) (
  input  logic       clk,
  input  logic       rst,
  output txStrobes_t strobes,
  output logic       sckOut,
  output logic       wsOut
);

  localparam int HALF = CLK_DIV / 2;
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW   = $clog2(WORD_LEN);

  logic [DW-1:0] divCnt;
  logic          sckQ;
  logic [BW-1:0] bitPos;
  logic          chanQ;   // 0 = left, 1 = right
  logic          wsQ;

  logic          edgeTick;
  logic          fallTick;
  logic          lastBit;
  logic [BW-1:0] nextPos;
  logic          nextChan;
  logic          nextWs;

  // Bit-clock divider
  assign edgeTick = (divCnt == DW'(HALF - 1));
  assign fallTick = edgeTick && sckQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt <= '0;
      sckQ   <= 1'b0;
    end else if (edgeTick) begin
      divCnt <= '0;
      sckQ   <= ~sckQ;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // Slot position and channel
  assign lastBit  = (bitPos == BW'(WORD_LEN - 1));
  assign nextPos  = lastBit ? '0 : bitPos + 1'b1;
  assign nextChan = lastBit ? ~chanQ : chanQ;
  // Word select leads the data by one period: it flips during the LSB.
  assign nextWs   = (nextPos == BW'(WORD_LEN - 1)) ? ~nextChan : nextChan;

  // The reset state stands for the LSB period of a right word, so the first
  // falling edge opens a left slot.
  always_ff @(posedge clk) begin
    if (rst) begin
      bitPos <= BW'(WORD_LEN - 1);
      chanQ  <= 1'b1;
      wsQ    <= 1'b0;
    end else if (fallTick) begin
      bitPos <= nextPos;
      chanQ  <= nextChan;
      wsQ    <= nextWs;
    end
  end

  always_comb begin
    strobes.loadLeft  = fallTick && lastBit && chanQ;
    strobes.loadRight = fallTick && lastBit && !chanQ;
    strobes.shift     = fallTick && !lastBit;
  end

  assign sckOut = sckQ;
  assign wsOut  = wsQ;

endmodule

// File: rtl/i2s_tx_datapath.sv
module i2s_tx_datapath
  import i2s_tx_pkg::*;
#(
  parameter int WORD_LEN = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  txStrobes_t          strobes,
  input  logic [WORD_LEN-1:0] inLeft,
  input  logic [WORD_LEN-1:0] inRight,
  input  logic                inValid,
  output logic                sdOut
);

  logic [WORD_LEN-1:0] holdL;
  logic [WORD_LEN-1:0] holdR;
  logic [WORD_LEN-1:0] shReg;
  logic                sdQ;
  logic [WORD_LEN-1:0] leftSrc;

  assign leftSrc = inValid ? inLeft : holdL;

  // Holding register: replaced only at a left-slot start with valid input
  always_ff @(posedge clk) begin
    if (rst) begin
      holdL <= '0;
      holdR <= '0;
    end else if (strobes.loadLeft && inValid) begin
      holdL <= inLeft;
      holdR <= inRight;
    end
  end

  // Output shifter, MSB first
  always_ff @(posedge clk) begin
    if (rst) begin
      shReg <= '0;
      sdQ   <= 1'b0;
    end else if (strobes.loadLeft) begin
      sdQ   <= leftSrc[WORD_LEN-1];
      shReg <= {leftSrc[WORD_LEN-2:0], 1'b0};
    end else if (strobes.loadRight) begin
      sdQ   <= holdR[WORD_LEN-1];
      shReg <= {holdR[WORD_LEN-2:0], 1'b0};
    end else if (strobes.shift) begin
      sdQ   <= shReg[WORD_LEN-1];
      shReg <= {shReg[WORD_LEN-2:0], 1'b0};
    end
  end

  assign sdOut = sdQ;

endmodule

// File: rtl/i2s_tx_master.sv
module i2s_tx_master
  import i2s_tx_pkg::*;
#(
  parameter int WORD_LEN = 24,
  parameter int CLK_DIV  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [WORD_LEN-1:0] inLeft,
  input  logic [WORD_LEN-1:0] inRight,
  input  logic                inValid,
  output logic                inReady,
  output logic                sckOut,
  output logic                wsOut,
  output logic                sdOut
);

  generate
    if (!(WORD_LEN == 16 || WORD_LEN == 18 || WORD_LEN == 20 || WORD_LEN == 24)) begin : g_badLen
      $error("WORD_LEN must be 16, 18, 20 or 24");
    end
    if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_badDiv
      $error("CLK_DIV must be even and at least 2");
    end
  endgenerate

  txStrobes_t strobes;

  i2s_tx_ctrl #(
    .WORD_LEN(WORD_LEN),
    .CLK_DIV (CLK_DIV)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .sckOut (sckOut),
    .wsOut  (wsOut)
  );

  i2s_tx_datapath #(
    .WORD_LEN(WORD_LEN)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .inLeft (inLeft),
    .inRight(inRight),
    .inValid(inValid),
    .sdOut  (sdOut)
  );

  assign inReady = strobes.loadLeft;

endmodule

// File: rtl/i2s_tx_master_chk.sv
module i2s_tx_master_chk #(
  parameter int WORD_LEN = 24,
  parameter int CLK_DIV  = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [WORD_LEN-1:0] inLeft,
  input logic                inValid,
  input logic                inReady,
  input logic                sckOut,
  input logic                wsOut,
  input logic                sdOut
);

  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = $clog2(CLK_DIV + 2) + 1;

  logic          sckPrev;
  logic [CW-1:0] levelCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sckPrev  <= 1'b0;
      levelCnt <= '0;
    end else begin
      sckPrev  <= sckOut;
      levelCnt <= (sckOut != sckPrev) ? CW'(1) : levelCnt + 1'b1;
    end
  end

  AST_SCK_HALF_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (sckOut != sckPrev) |-> (levelCnt == CW'(HALF))); // R1

  AST_SCK_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    levelCnt <= CW'(HALF)); // R1

  AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdOut) |-> $fell(sckOut)); // R4

  AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(wsOut) |-> $fell(sckOut)); // R3

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    inReady |=> !inReady); // R5

  AST_READY_OPENS_LEFT: assert property (@(posedge clk) disable iff (rst)
    inReady |=> ($fell(sckOut) && !wsOut)); // R5

  AST_CAPTURE_MSB: assert property (@(posedge clk) disable iff (rst)
    (inReady && inValid) |=> (sdOut == $past(inLeft[WORD_LEN-1]))); // R5

endmodule

bind i2s_tx_master i2s_tx_master_chk #(
  .WORD_LEN(WORD_LEN),
  .CLK_DIV (CLK_DIV)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .inLeft (inLeft),
  .inValid(inValid),
  .inReady(inReady),
  .sckOut (sckOut),
  .wsOut  (wsOut),
  .sdOut  (sdOut)
);

// File: tb/i2s_tx_master_tb.sv
`timescale 1ns/1ps
module i2s_tx_master_tb;

  localparam int N       = 24;
  localparam int DIV     = 4;
  localparam int HALF    = DIV / 2;
  localparam int FRAMES  = 12;
  localparam real TCLK   = 20.0;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] inLeft = '0;
  logic [N-1:0] inRight = '0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic         sckOut;
  logic         wsOut;
  logic         sdOut;

  int checks = 0;
  int fails  = 0;
  bit monDone = 1'b0;

  typedef struct { bit ch; logic [N-1:0] val; } item_t;
  item_t expQ[$];

  logic [N-1:0] lastL = '0;
  logic [N-1:0] lastR = '0;

  always #10 clk = ~clk;

  i2s_tx_master #(.WORD_LEN(N), .CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .inLeft(inLeft), .inRight(inRight),
    .inValid(inValid), .inReady(inReady), .sckOut(sckOut),
    .wsOut(wsOut), .sdOut(sdOut)
  );

  task automatic check(input bit ok, input string req, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: one call per frame; waits for the capture window.
  realtime lastReady = 0.0;
  int      readyCount = 0;
  task automatic sendFrame(input logic [N-1:0] l, input logic [N-1:0] r, input bit v);
    @(negedge clk);
    inLeft  = l;
    inRight = r;
    inValid = v;
    while (inReady !== 1'b1) @(negedge clk);
    if (readyCount > 0)
      check(($realtime - lastReady) == 2.0 * N * DIV * TCLK, "R5 ready spacing",
            N'(int'(($realtime - lastReady) / TCLK)), N'(2 * N * DIV));
    lastReady = $realtime;
    readyCount++;
    if (v) begin
      lastL = l;
      lastR = r;
    end
    expQ.push_back('{ch: 1'b0, val: lastL});
    expQ.push_back('{ch: 1'b1, val: lastR});
    @(negedge clk);
    check(inReady === 1'b0, "R5 ready one cycle", N'(inReady), '0);
    inValid = 1'b0;
  endtask

  // Monitor: receiver model sampling at rising bit-clock edges.
  initial begin : monitor
    logic [N-1:0] word;
    bit           wsBad;
    bit           ch;
    item_t        e;
    wait (rst == 1'b0);
    @(posedge sckOut); #1;   // R7: leading period carries no word
    check(wsOut === 1'b0 && sdOut === 1'b0, "R7 idle first period",
          N'({wsOut, sdOut}), '0);
    for (int w = 0; w < 2 * FRAMES; w++) begin
      ch    = w[0];
      word  = '0;
      wsBad = 1'b0;
      for (int b = 0; b < N; b++) begin
        @(posedge sckOut); #1;
        word = {word[N-2:0], sdOut};
        if (wsOut !== ((b == N - 1) ? ~ch : ch)) wsBad = 1'b1;
      end
      check(!wsBad, "R2 R3 word select pattern", N'(w), N'(w));
      if (expQ.size() == 0) begin
        check(1'b0, "R4 no expected word", word, '0);
      end else begin
        e = expQ.pop_front();
        check(e.ch == ch, "R2 channel order", N'(ch), N'(e.ch));
        check(word === e.val, ch ? "R4 R6 right word" : "R4 R6 left word", word, e.val);
      end
    end
    monDone = 1'b1;
  end

  // Bit-clock timing (R1)
  initial begin : sckTiming
    realtime t1, t2, t3;
    wait (rst == 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(posedge sckOut); t1 = $realtime;
      @(negedge sckOut); t2 = $realtime;
      @(posedge sckOut); t3 = $realtime;
      check((t2 - t1) == HALF * TCLK, "R1 high time", N'(int'((t2 - t1) / TCLK)), N'(HALF));
      check((t3 - t1) == DIV * TCLK, "R1 period", N'(int'((t3 - t1) / TCLK)), N'(DIV));
    end
  end

  // Stimulus
  initial begin : stim
    repeat (4) @(posedge clk);
    #1;
    check(sckOut === 1'b0 && wsOut === 1'b0 && sdOut === 1'b0 && inReady === 1'b0,
          "R7 reset outputs", N'({sckOut, wsOut, sdOut, inReady}), '0);
    @(negedge clk);
    rst = 1'b0;
    sendFrame(24'h123456, 24'hABCDEF, 1'b0);   // R6: reset pair of zeros repeated
    sendFrame(24'h800000, 24'h7FFFFF, 1'b1);   // extremes of two's complement
    sendFrame(24'hAAAAAA, 24'h555555, 1'b1);
    sendFrame(24'h000001, 24'hFFFFFF, 1'b1);
    sendFrame(24'h111111, 24'h222222, 1'b0);   // R6: repeat previous pair
    sendFrame(24'h333333, 24'h444444, 1'b0);
    for (int f = 0; f < FRAMES - 6; f++)
      sendFrame(N'(32'h9E3779 * (f + 3)), N'(32'h5BD1E9 ^ (f * 32'h010203)), 1'b1);
  end

  // Watchdog and summary
  initial begin : finisher
    int cyc = 0;
    while (!monDone && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!monDone) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule